// File: doc/BRIEF.md
# Low-Speed USB Line Receiver

This block takes the two data lines of a low-speed USB link and turns the traffic on them into bytes. The link runs at 1.5 Mbit/s, and the block runs on a fast system clock that has no fixed relation to the sender. Both line inputs pass through a synchronizer. The block then sorts each sample into one of four line conditions: idle-polarity J, opposite-polarity K, single-ended zero, or the illegal both-high state. The current condition is available on an output at all times.

A phase counter sets when each bit is sampled. Every change of line condition restarts the counter, so the next sample lands half a bit later. Between line changes, the counter repeats a 53, 53, 54 clock pattern to match the 1.5 Mbit/s bit period at roughly 80 MHz. Each sample decision uses the line value registered one clock before the decision. A restart that falls exactly on a sample point therefore produces one sample of the old bit, and the new bit is sampled half a bit later. It can never produce two samples of the same bit.

A four-state machine (IDLE, SYNC, DATA, EOP) does the decoding. It looks for the alternating sync pattern first. It then decodes NRZI, removes stuffed bits and packs the bits into bytes, least significant bit first. It also detects end of packet and flags stuffing violations.

Top module: `usb_ls_rx`

The state machine moves between its states as follows:
- IDLE to SYNC on a K sample (`go_sync`).
- SYNC stays in SYNC on each alternation (`sync_toggle`).
- SYNC to DATA on two K samples in a row after enough alternations (`sync_lock`).
- SYNC to IDLE on any other sample (`sync_abort`).
- DATA to EOP on an SE0 sample (`go_eop`).
- DATA to IDLE on a stuffing violation or a both-high sample (`data_abort`).
- EOP stays in EOP while SE0 continues (`eop_hold`).
- EOP to IDLE on J (`eop_done`) or on anything else (`eop_abort`).

## Requirements
- R1: `line_state` equals {D+, D-} of the pins as they were three clocks earlier: 2'b00 is SE0, 2'b01 is J (D- high), 2'b10 is K, 2'b11 is both high.
- R2: While reset is held and right after it is released, `line_state` reads J and every strobe output is 0.
- R3: After any change of line condition, the next sample is taken exactly `HALF_CLKS` clocks later, whatever the phase of the counter when the change arrives.
- R4: With no line change in between, consecutive samples are `BIT_CLKS_A` or `BIT_CLKS_B` clocks apart, in the repeating order A, A, B.
- R5: Each sample uses the line value registered on the clock before the sample decision, and two sample strobes never occur in consecutive clocks.
- R6: Byte capture begins only after a K followed by at least four alternating samples ending in K and then a second K. `pkt_start` pulses for one clock when capture begins.
- R7: A sample equal to the previous sample decodes as 1, and a changed sample decodes as 0. Bits are packed least significant bit first, and `rx_valid` pulses for one clock with each complete byte on `rx_byte`.
- R8: A 0 bit that follows six consecutive 1s is removed from the data. The final K-K of the sync pattern counts as the first of those 1s.
- R9: A 1 bit that follows six consecutive 1s pulses `stuff_err`, delivers no byte and returns the decoder to IDLE.
- R10: An SE0 sample during capture, followed by a J sample, pulses `pkt_end` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_dp | input | 1 | D+ line (even pin), asynchronous |
| pin_dm | input | 1 | D- line (odd pin), asynchronous |
| line_state | output | 2 | Current classified line condition |
| rx_byte | output | 8 | Last decoded byte |
| rx_valid | output | 1 | One-clock strobe: `rx_byte` is new |
| pkt_start | output | 1 | One-clock strobe: sync recognised |
| pkt_end | output | 1 | One-clock strobe: end of packet |
| stuff_err | output | 1 | One-clock strobe: stuffing violation |

## Verification
Packets are sent after idle gaps of 0, 5, 13, 27, 40 and 52 clocks, so the first sync edge meets the phase counter at many different phases, including ones close to a sample point.

The payloads are chosen to test different parts of the decoder:
- Bytes made mostly of 0s give a line change at every bit, so they test restarting and NRZI decoding.
- 0xFF pairs give long runs with no line change, so they test the A, A, B cadence and the removal of stuffed bits.
- Mixed values test byte packing order.

A truncated sync pattern must produce no strobes at all. A run of seven 1s must produce a stuffing error and no byte. A packet sent after that error must still be decoded, which shows the decoder recovers.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

    // Value is {D+, D-}
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_EOP
    } rx_state_t;

endpackage

// File: rtl/usb_ls_line_sync.sv
module usb_ls_line_sync
    import usb_ls_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_dp,
    input  logic  pin_dm,
    output line_t ls_now,
    output line_t ls_prior,
    output logic  edge_seen
);

    logic [1:0] stage_q [STAGES];
    line_t      cur_q;
    line_t      prior_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 2'b01;
                else        stage_q[g] <= {pin_dp, pin_dm};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 2'b01;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    // Classified value and the value one clock older (R1, R5)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= LS_J;
            prior_q <= LS_J;
        end else begin
            cur_q   <= line_t'(stage_q[STAGES-1]);
            prior_q <= cur_q;
        end
    end

    assign ls_now    = cur_q;
    assign ls_prior  = prior_q;
    assign edge_seen = (cur_q != prior_q);

endmodule

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
    parameter int BIT_CLKS_A = 53,
    parameter int BIT_CLKS_B = 54,
    parameter int HALF_CLKS  = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    output logic sample_stb
);

    localparam int CNT_W = $clog2(BIT_CLKS_B + 1);
    localparam int GAP_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] RELOAD_A = CNT_W'(BIT_CLKS_A - 1);
    localparam logic [CNT_W-1:0] RELOAD_B = CNT_W'(BIT_CLKS_B - 1);
    localparam logic [CNT_W-1:0] RELOAD_H = CNT_W'(HALF_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       cad_q;

    assign sample_stb = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD_A;
            cad_q <= 2'd0;
        end else if (edge_seen) begin
            cnt_q <= RELOAD_H;                 // R3: restart half a bit out
            cad_q <= 2'd0;
        end else if (sample_stb) begin
            cnt_q <= (cad_q == 2'd2) ? RELOAD_B : RELOAD_A;   // R4
            cad_q <= (cad_q == 2'd2) ? 2'd0 : cad_q + 2'd1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Checker state: clocks since the last strobe or edge
    logic [GAP_W-1:0] gap_q;
    logic             seen_edge_q;
    logic             primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= '0;
            seen_edge_q <= 1'b0;
            primed_q    <= 1'b0;
        end else begin
            if (edge_seen || sample_stb) gap_q <= GAP_W'(1);
            else if (gap_q != '1)        gap_q <= gap_q + 1'b1;
            if (edge_seen)       seen_edge_q <= 1'b1;
            else if (sample_stb) seen_edge_q <= 1'b0;
            if (edge_seen || sample_stb) primed_q <= 1'b1;
        end
    end

    a_r3_half_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && seen_edge_q) |-> (gap_q == GAP_W'(HALF_CLKS)));

    a_r4_cadence: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && primed_q && !seen_edge_q) |->
            (gap_q == GAP_W'(BIT_CLKS_A) || gap_q == GAP_W'(BIT_CLKS_B)));

    a_r5_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

endmodule

// File: rtl/usb_ls_decoder.sv
module usb_ls_decoder
    import usb_ls_rx_pkg::*;
#(
    parameter int SYNC_MIN  = 4,
    parameter int STUFF_RUN = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_stb,
    input  line_t      sample_ls,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       pkt_start,
    output logic       pkt_end,
    output logic       stuff_err
);

    localparam int ALT_W  = $clog2(SYNC_MIN + 2);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);

    rx_state_t         state_q, state_d;
    line_t             last_q;
    logic [ALT_W-1:0]  alt_q;
    logic [ONES_W-1:0] ones_q;
    logic [2:0]        bit_q;
    logic [7:0]        shift_q;

    logic is_jk, nrzi_bit, at_run, sync_ok, bad_stuff;

    assign is_jk     = (sample_ls == LS_J) || (sample_ls == LS_K);
    assign nrzi_bit  = (sample_ls == last_q);                        // R7
    assign at_run    = (ones_q == ONES_W'(STUFF_RUN));
    assign sync_ok   = (last_q == LS_K) && (alt_q >= ALT_W'(SYNC_MIN));
    assign bad_stuff = (state_q == ST_DATA) && sample_stb && is_jk && at_run && nrzi_bit;

    // Next state
    always_comb begin
        state_d = state_q;
        if (sample_stb) begin
            unique case (state_q)
                ST_IDLE: if (sample_ls == LS_K) state_d = ST_SYNC;      // go_sync
                ST_SYNC: begin
                    if (!is_jk)                   state_d = ST_IDLE;    // sync_abort
                    else if (sample_ls != last_q) state_d = ST_SYNC;    // sync_toggle
                    else if (sync_ok)             state_d = ST_DATA;    // sync_lock
                    else                          state_d = ST_IDLE;    // sync_abort
                end
                ST_DATA: begin
                    if (sample_ls == LS_SE0)      state_d = ST_EOP;     // go_eop
                    else if (!is_jk || bad_stuff) state_d = ST_IDLE;    // data_abort
                end
                ST_EOP: begin
                    if (sample_ls != LS_SE0)      state_d = ST_IDLE;    // eop_done / eop_abort
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q    <= LS_J;
            alt_q     <= '0;
            ones_q    <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            pkt_start <= 1'b0;
            pkt_end   <= 1'b0;
            stuff_err <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            pkt_start <= 1'b0;
            pkt_end   <= 1'b0;
            stuff_err <= 1'b0;
            if (sample_stb) begin
                last_q <= sample_ls;
                unique case (state_q)
                    ST_IDLE: alt_q <= ALT_W'(1);
                    ST_SYNC: begin
                        if (is_jk && sample_ls != last_q && alt_q != '1)
                            alt_q <= alt_q + 1'b1;
                        if (state_d == ST_DATA) begin               // R6
                            pkt_start <= 1'b1;
                            ones_q    <= ONES_W'(1);                // R8: sync K-K counts
                            bit_q     <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (is_jk) begin
                            if (at_run) begin
                                ones_q <= '0;
                                if (nrzi_bit) stuff_err <= 1'b1;    // R9
                                // else: stuffed zero dropped (R8)
                            end else begin
                                ones_q  <= nrzi_bit ? ones_q + 1'b1 : '0;
                                shift_q <= {nrzi_bit, shift_q[7:1]};
                                bit_q   <= bit_q + 1'b1;
                                if (bit_q == 3'd7) begin            // R7
                                    rx_byte  <= {nrzi_bit, shift_q[7:1]};
                                    rx_valid <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_EOP: if (sample_ls == LS_J) pkt_end <= 1'b1; // R10
                    default: ;
                endcase
            end
        end
    end

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, pkt_start, pkt_end, stuff_err}));

    a_r8_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= ONES_W'(STUFF_RUN));

    a_r6_start_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_DATA) |-> $past(state_q == ST_SYNC));

    a_r10_end_from_eop: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> $past(state_q == ST_EOP));

    a_r9_err_leaves_data: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> (state_q == ST_IDLE));

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BIT_CLKS_A  = 53,
    parameter int BIT_CLKS_B  = 54,
    parameter int HALF_CLKS   = 27,
    parameter int SYNC_MIN    = 4,
    parameter int STUFF_RUN   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_dp,
    input  logic       pin_dm,
    output logic [1:0] line_state,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       pkt_start,
    output logic       pkt_end,
    output logic       stuff_err
);

    line_t ls_now, ls_prior;
    logic  edge_seen, sample_stb;

    usb_ls_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_dp    (pin_dp),
        .pin_dm    (pin_dm),
        .ls_now    (ls_now),
        .ls_prior  (ls_prior),
        .edge_seen (edge_seen)
    );

    usb_ls_bit_timer #(
        .BIT_CLKS_A (BIT_CLKS_A),
        .BIT_CLKS_B (BIT_CLKS_B),
        .HALF_CLKS  (HALF_CLKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_seen  (edge_seen),
        .sample_stb (sample_stb)
    );

    usb_ls_decoder #(
        .SYNC_MIN  (SYNC_MIN),
        .STUFF_RUN (STUFF_RUN)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .sample_ls  (ls_prior),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .pkt_start  (pkt_start),
        .pkt_end    (pkt_end),
        .stuff_err  (stuff_err)
    );

    assign line_state = ls_now;

endmodule

// File: tb/usb_ls_rx_tb_top.sv
module usb_ls_rx_tb_top;

    localparam int K_START = 1, K_BYTE = 2, K_END = 3, K_ERR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_dp = 1'b0;
    logic       pin_dm = 1'b1;
    logic [1:0] line_state;
    logic [7:0] rx_byte;
    logic       rx_valid, pkt_start, pkt_end, stuff_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    int  exp_q[$];
    byte unsigned tx_q[$];
    int  cad = 0;

    always #4 clk = ~clk;

    usb_ls_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_dp     (pin_dp),
        .pin_dm     (pin_dm),
        .line_state (line_state),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .pkt_start  (pkt_start),
        .pkt_end    (pkt_end),
        .stuff_err  (stuff_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string kind_tag(input int code);
        case (code / 256)
            K_START: return "R6 packet start";
            K_BYTE:  return "R7 byte (R8 when stuffed)";
            K_END:   return "R10 packet end";
            default: return "R9 stuff error";
        endcase
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (rx_valid || pkt_start || pkt_end || stuff_err)) begin
            int code;
            code = pkt_start ? K_START * 256 :
                   pkt_end   ? K_END * 256 :
                   stuff_err ? K_ERR * 256 : K_BYTE * 256 + int'(rx_byte);
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected strobe", code, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(code == e, kind_tag(e), code, e);
            end
        end
    end

    // Hold a line condition for one bit: 53, 53, 54 clocks
    task automatic drive_ls(input logic [1:0] ls);
        pin_dp = ls[1];
        pin_dm = ls[0];
        repeat ((cad == 2) ? 54 : 53) @(negedge clk);
        cad = (cad == 2) ? 0 : cad + 1;
    endtask

    task automatic send_pkt(input int idle_clks, input bit do_stuff, input bit push_exp);
        bit          bits[$];
        int          ones;
        logic [1:0]  lvl;
        for (int i = 0; i < 7; i++) bits.push_back(1'b0);
        bits.push_back(1'b1);
        ones = 1;
        foreach (tx_q[n]) begin
            for (int i = 0; i < 8; i++) begin
                bit b;
                b = tx_q[n][i];
                bits.push_back(b);
                ones = b ? ones + 1 : 0;
                if (do_stuff && ones == 6) begin
                    bits.push_back(1'b0);
                    ones = 0;
                end
            end
        end
        if (push_exp) begin
            exp_q.push_back(K_START * 256);
            foreach (tx_q[n]) exp_q.push_back(K_BYTE * 256 + int'(tx_q[n]));
            exp_q.push_back(K_END * 256);
        end
        repeat (idle_clks) @(negedge clk);
        lvl = 2'b01;
        foreach (bits[i]) begin
            if (!bits[i]) lvl = (lvl == 2'b01) ? 2'b10 : 2'b01;
            drive_ls(lvl);
        end
        drive_ls(2'b00);
        drive_ls(2'b00);
        drive_ls(2'b01);
    endtask

    initial begin
        // R2: reset state
        repeat (3) @(negedge clk);
        check(line_state == 2'b01, "R2 line_state in reset", line_state, 1);
        check({rx_valid, pkt_start, pkt_end, stuff_err} == 4'b0, "R2 strobes in reset",
              {rx_valid, pkt_start, pkt_end, stuff_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(line_state == 2'b01, "R2 line_state after release", line_state, 1);
        check(rx_byte == 8'h00, "R2 rx_byte after release", rx_byte, 0);

        // R1: classification, three clocks of latency
        {pin_dp, pin_dm} = 2'b10;
        repeat (2) @(negedge clk);
        check(line_state == 2'b01, "R1 not yet visible", line_state, 1);
        @(negedge clk);
        check(line_state == 2'b10, "R1 K", line_state, 2);
        {pin_dp, pin_dm} = 2'b00;
        repeat (3) @(negedge clk);
        check(line_state == 2'b00, "R1 SE0", line_state, 0);
        {pin_dp, pin_dm} = 2'b11;
        repeat (3) @(negedge clk);
        check(line_state == 2'b11, "R1 SE1", line_state, 3);
        {pin_dp, pin_dm} = 2'b01;
        repeat (3) @(negedge clk);
        check(line_state == 2'b01, "R1 J", line_state, 1);
        repeat (200) @(negedge clk);

        // R3 R7: packets starting at assorted phases
        tx_q = '{8'hA5};               send_pkt(0,  1'b1, 1'b1);
        tx_q = '{8'h00, 8'h3C};        send_pkt(13, 1'b1, 1'b1);
        // R4 R8: long runs and stuffed bits
        tx_q = '{8'hFF, 8'hFF};        send_pkt(27, 1'b1, 1'b1);
        tx_q = '{8'h7E, 8'h81, 8'hC3}; send_pkt(52, 1'b1, 1'b1);

        // R6: truncated sync K J K K gives nothing
        repeat (26) @(negedge clk);
        drive_ls(2'b10); drive_ls(2'b01); drive_ls(2'b10);
        drive_ls(2'b10); drive_ls(2'b10);
        drive_ls(2'b00); drive_ls(2'b00); drive_ls(2'b01);
        repeat (100) @(negedge clk);
        check(exp_q.size() == 0, "R6 truncated sync silent", exp_q.size(), 0);

        // R9: seven ones without stuffing
        exp_q.push_back(K_START * 256);
        exp_q.push_back(K_ERR * 256);
        tx_q = '{8'hFF};               send_pkt(40, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        check(exp_q.size() == 0, "R9 error reported, no byte", exp_q.size(), 0);

        // Recovery after error
        tx_q = '{8'h5A};               send_pkt(5, 1'b1, 1'b1);

        repeat (300) @(negedge clk);
        check(exp_q.size() == 0, "R10 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired R7 actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule